// File: doc/BRIEF.md
# Multi-Mode Power Mode Controller

This block sequences the power state of a small processor domain. Software writes a 2-bit mode field that asks for one of three states. In active, everything runs. In flexi, the CPU clock stops but a chosen set of peripherals keeps its clocks. In hibernate, the main logic is power gated, SRAM is retained only in the banks that were asked for, and the high-speed oscillator is stopped. From its own state the block drives the CPU clock enable, per-peripheral clock enables, the logic and SRAM power gates, the SRAM retention controls, the high-speed oscillator enable and the sensor-bias enables.

Entry to hibernate is a chain of steps, and each step advances on a one-cycle acknowledge. The steps are: stop the clocks, retain, cut power to the unretained banks and the logic, stop the oscillator. A wake event runs the chain in reverse. It restarts the oscillator, waits for it to report ready, restores power, releases retention, restarts the clocks, and writes the mode field back to active. A debug hold input keeps the CPU clocked in flexi, stops hibernate entry from starting, and freezes an entry already under way. A status output reports the state actually in effect.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, mode_field_o and mode_stat_o are 00, all clock, power, oscillator and bias enables are 1, and sram_ret_o is all 0.
- R2: A write stores 00 (active), 01 (flexi) or 10 (hibernate) in mode_field_o on the clock edge of the write. A write of 11 stores 00.
- R3: In flexi, cpu_clk_en_o is 0, per_clk_en_o[i] follows per_mask_i[i], and mode_stat_o is 01. Writing 00 or 11 returns the block to active.
- R4: Hibernate entry starts one edge after the field reads 10. It steps through these states in order: clocks gated (all clock enables 0), retention asserted, power cut, oscillator stopped, hibernate. Each step advances only on an edge where step_ack_i is 1.
- R5: Bit 0 of sram_ret_o and sram_pwr_en_o is the fixed bank, and it is always retained. Bit k+1 is retained when ret_mask_i[k] was 1 on the edge that started entry. Changes to the mask after that edge have no effect.
- R6: From the power-cut step until the wake oscillator step ends, logic_pwr_en_o is 0, sram_pwr_en_o equals the retention vector, and bias_en_o equals keep_mask_i as captured when entry started.
- R7: In hibernate, mode_stat_o is 10, hs_osc_en_o and all clock enables are 0, and the block stays there until wake_i is 1. step_ack_i has no effect.
- R8: On wake, hs_osc_en_o returns to 1 with power still cut until osc_rdy_i is 1. Then all power returns with retention held until an acknowledge. Then retention is released with clocks still off until an acknowledge. Then the block is active and mode_field_o reads 00.
- R9: While dbg_hold_i is 1, hibernate entry does not start, entry steps do not advance, and in flexi cpu_clk_en_o is 1 with mode_stat_o 00.
- R10: mode_stat_o is 11 in every entry and wake step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Mode field write strobe |
| mode_wdata_i | input | 2 | Mode field write data |
| ret_mask_i | input | NB_OPT | Optional SRAM banks to retain |
| per_mask_i | input | NPER | Peripherals clocked in flexi |
| keep_mask_i | input | NBIAS | Bias circuits kept on in power-down |
| dbg_hold_i | input | 1 | Debugger hold |
| wake_i | input | 1 | Wake event |
| step_ack_i | input | 1 | Acknowledge of the current sequence step |
| osc_rdy_i | input | 1 | High-speed oscillator ready |
| mode_field_o | output | 2 | Stored mode field |
| mode_stat_o | output | 2 | Mode in effect (11 = in transition) |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | NPER | Peripheral clock enables |
| logic_pwr_en_o | output | 1 | Main logic power enable |
| sram_pwr_en_o | output | NB_OPT+1 | SRAM bank power enables, bit 0 fixed bank |
| sram_ret_o | output | NB_OPT+1 | SRAM bank retention controls |
| hs_osc_en_o | output | 1 | High-speed oscillator enable |
| bias_en_o | output | NBIAS | Sensor-bias circuit enables |

## Verification
The hardest case to reach is a debug hold that arrives in the middle of hibernate entry, with the sequence already past clock gating and retention already asserted. The stimulus requests hibernate with the hold high first, so that entry does not start. It then drops the hold, steps one acknowledge into retention, and raises the hold again while pulsing an acknowledge. The bench checks that retention stays asserted and power stays on. While the block sits in power-down, it also changes the retention mask and pulses acknowledges, and checks that neither has any effect.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;
  typedef enum logic [1:0] {
    MODE_ACT = 2'b00,
    MODE_FLX = 2'b01,
    MODE_HIB = 2'b10,
    MODE_RSV = 2'b11
  } mode_e;

  typedef enum logic [3:0] {
    S_ACT, S_FLX,
    S_E_CLK, S_E_RET, S_E_PWR, S_E_OSC,
    S_HIB,
    S_W_OSC, S_W_PWR, S_W_CLK
  } state_e;

  localparam logic [1:0] STAT_BUSY = 2'b11;
endpackage

// File: rtl/pmc_mode_reg.sv
`timescale 1ns/1ps
module pmc_mode_reg
  import pmc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [1:0] wdata_i,
  input  logic       clr_i,
  output mode_e      mode_o
);
  mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mode_q <= MODE_ACT;
    else if (clr_i) mode_q <= MODE_ACT;
    else if (we_i)  mode_q <= (wdata_i == MODE_RSV) ? MODE_ACT : mode_e'(wdata_i);
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/pmc_seq.sv
`timescale 1ns/1ps
module pmc_seq
  import pmc_pkg::*;
#(
  parameter int NB_OPT = 3,
  parameter int NBIAS  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mode_e             mode_i,
  input  logic              dbg_hold_i,
  input  logic              wake_i,
  input  logic              ack_i,
  input  logic              osc_rdy_i,
  input  logic [NB_OPT-1:0] ret_mask_i,
  input  logic [NBIAS-1:0]  keep_i,
  output state_e            st_o,
  output logic              clr_o,
  output logic [NB_OPT-1:0] ret_q_o,
  output logic [NBIAS-1:0]  keep_q_o
);
  state_e st_q, st_d;
  logic   step;
  logic   start;

  assign step = ack_i && !dbg_hold_i;

  always_comb begin
    st_d  = st_q;
    clr_o = 1'b0;
    unique case (st_q)
      S_ACT: if (mode_i == MODE_HIB && !dbg_hold_i) st_d = S_E_CLK;
             else if (mode_i == MODE_FLX)           st_d = S_FLX;
      S_FLX: if (mode_i == MODE_HIB && !dbg_hold_i) st_d = S_E_CLK;
             else if (mode_i != MODE_FLX && mode_i != MODE_HIB) st_d = S_ACT;
      S_E_CLK: if (step) st_d = S_E_RET;
      S_E_RET: if (step) st_d = S_E_PWR;
      S_E_PWR: if (step) st_d = S_E_OSC;
      S_E_OSC: if (step) st_d = S_HIB;
      S_HIB:   if (wake_i) st_d = S_W_OSC;
      S_W_OSC: if (osc_rdy_i) st_d = S_W_PWR;
      S_W_PWR: if (ack_i) st_d = S_W_CLK;
      S_W_CLK: if (ack_i) begin
                 st_d  = S_ACT;
                 clr_o = 1'b1;
               end
      default: st_d = S_ACT;
    endcase
  end

  assign start = (st_q == S_ACT || st_q == S_FLX) && st_d == S_E_CLK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_ACT;
      ret_q_o  <= '0;
      keep_q_o <= '0;
    end else begin
      st_q <= st_d;
      if (start) begin
        ret_q_o  <= ret_mask_i;
        keep_q_o <= keep_i;
      end
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/pmc_out.sv
`timescale 1ns/1ps
module pmc_out
  import pmc_pkg::*;
#(
  parameter int NB_OPT = 3,
  parameter int NPER   = 4,
  parameter int NBIAS  = 3
) (
  input  state_e            st_i,
  input  logic              dbg_hold_i,
  input  logic [NPER-1:0]   per_mask_i,
  input  logic [NB_OPT-1:0] ret_q_i,
  input  logic [NBIAS-1:0]  keep_q_i,
  output logic [1:0]        stat_o,
  output logic              cpu_clk_en_o,
  output logic [NPER-1:0]   per_clk_en_o,
  output logic              logic_pwr_en_o,
  output logic [NB_OPT:0]   sram_pwr_en_o,
  output logic [NB_OPT:0]   sram_ret_o,
  output logic              hs_osc_en_o,
  output logic [NBIAS-1:0]  bias_en_o
);
  localparam int NBANK = NB_OPT + 1;

  logic in_pd, in_ret, osc_off;
  logic [NBANK-1:0] ret_vec;

  assign in_pd   = st_i inside {S_E_PWR, S_E_OSC, S_HIB, S_W_OSC};
  assign in_ret  = st_i inside {S_E_RET, S_E_PWR, S_E_OSC, S_HIB, S_W_OSC, S_W_PWR};
  assign osc_off = st_i inside {S_E_OSC, S_HIB};

  assign ret_vec[0] = 1'b1;  // fixed bank
  for (genvar b = 1; b < NBANK; b++) begin : g_bank
    assign ret_vec[b]       = ret_q_i[b-1];
    assign sram_ret_o[b]    = in_ret && ret_vec[b];
    assign sram_pwr_en_o[b] = !in_pd || ret_vec[b];
  end
  assign sram_ret_o[0]    = in_ret;
  assign sram_pwr_en_o[0] = 1'b1;

  assign logic_pwr_en_o = !in_pd;
  assign hs_osc_en_o    = !osc_off;
  assign bias_en_o      = in_pd ? keep_q_i : '1;
  assign cpu_clk_en_o   = (st_i == S_ACT) || (st_i == S_FLX && dbg_hold_i);

  always_comb begin
    unique case (st_i)
      S_ACT:   per_clk_en_o = '1;
      S_FLX:   per_clk_en_o = per_mask_i;
      default: per_clk_en_o = '0;
    endcase
  end

  always_comb begin
    unique case (st_i)
      S_ACT:   stat_o = MODE_ACT;
      S_FLX:   stat_o = dbg_hold_i ? MODE_ACT : MODE_FLX;
      S_HIB:   stat_o = MODE_HIB;
      default: stat_o = STAT_BUSY;
    endcase
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
`timescale 1ns/1ps
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int NB_OPT = 3,
  parameter int NPER   = 4,
  parameter int NBIAS  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic [1:0]        mode_wdata_i,
  input  logic [NB_OPT-1:0] ret_mask_i,
  input  logic [NPER-1:0]   per_mask_i,
  input  logic [NBIAS-1:0]  keep_mask_i,
  input  logic              dbg_hold_i,
  input  logic              wake_i,
  input  logic              step_ack_i,
  input  logic              osc_rdy_i,
  output logic [1:0]        mode_field_o,
  output logic [1:0]        mode_stat_o,
  output logic              cpu_clk_en_o,
  output logic [NPER-1:0]   per_clk_en_o,
  output logic              logic_pwr_en_o,
  output logic [NB_OPT:0]   sram_pwr_en_o,
  output logic [NB_OPT:0]   sram_ret_o,
  output logic              hs_osc_en_o,
  output logic [NBIAS-1:0]  bias_en_o
);
  mode_e             mode;
  state_e            st;
  logic              clr;
  logic [NB_OPT-1:0] ret_q;
  logic [NBIAS-1:0]  keep_q;

  pmc_mode_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mode_we_i),
    .wdata_i (mode_wdata_i),
    .clr_i   (clr),
    .mode_o  (mode)
  );

  pmc_seq #(.NB_OPT(NB_OPT), .NBIAS(NBIAS)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .dbg_hold_i (dbg_hold_i),
    .wake_i     (wake_i),
    .ack_i      (step_ack_i),
    .osc_rdy_i  (osc_rdy_i),
    .ret_mask_i (ret_mask_i),
    .keep_i     (keep_mask_i),
    .st_o       (st),
    .clr_o      (clr),
    .ret_q_o    (ret_q),
    .keep_q_o   (keep_q)
  );

  pmc_out #(.NB_OPT(NB_OPT), .NPER(NPER), .NBIAS(NBIAS)) u_out (
    .st_i           (st),
    .dbg_hold_i     (dbg_hold_i),
    .per_mask_i     (per_mask_i),
    .ret_q_i        (ret_q),
    .keep_q_i       (keep_q),
    .stat_o         (mode_stat_o),
    .cpu_clk_en_o   (cpu_clk_en_o),
    .per_clk_en_o   (per_clk_en_o),
    .logic_pwr_en_o (logic_pwr_en_o),
    .sram_pwr_en_o  (sram_pwr_en_o),
    .sram_ret_o     (sram_ret_o),
    .hs_osc_en_o    (hs_osc_en_o),
    .bias_en_o      (bias_en_o)
  );

  assign mode_field_o = mode;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_chk #(
  parameter int NB_OPT = 3,
  parameter int NPER   = 4,
  parameter int NBIAS  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dbg_hold_i,
  input logic              wake_i,
  input logic [1:0]        mode_field_o,
  input logic [1:0]        mode_stat_o,
  input logic              cpu_clk_en_o,
  input logic [NPER-1:0]   per_clk_en_o,
  input logic              logic_pwr_en_o,
  input logic [NB_OPT:0]   sram_pwr_en_o,
  input logic [NB_OPT:0]   sram_ret_o,
  input logic              hs_osc_en_o
);
  assert_field_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_field_o != 2'b11);

  assert_ret_powered_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_ret_o & ~sram_pwr_en_o) == '0);

  assert_fixed_bank_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !logic_pwr_en_o |-> (sram_ret_o[0] && sram_pwr_en_o[0]));

  assert_cpu_powered_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_clk_en_o |-> logic_pwr_en_o);

  assert_osc_clk_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hs_osc_en_o |-> (!cpu_clk_en_o && per_clk_en_o == '0));

  assert_hib_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_stat_o == 2'b10 && !wake_i) |=> mode_stat_o == 2'b10);

  assert_osc_first_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(logic_pwr_en_o) |-> hs_osc_en_o);

  assert_dbg_block_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_hold_i && mode_stat_o != 2'b10) |=> mode_stat_o != 2'b10);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.NB_OPT(NB_OPT), .NPER(NPER), .NBIAS(NBIAS)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .dbg_hold_i     (dbg_hold_i),
  .wake_i         (wake_i),
  .mode_field_o   (mode_field_o),
  .mode_stat_o    (mode_stat_o),
  .cpu_clk_en_o   (cpu_clk_en_o),
  .per_clk_en_o   (per_clk_en_o),
  .logic_pwr_en_o (logic_pwr_en_o),
  .sram_pwr_en_o  (sram_pwr_en_o),
  .sram_ret_o     (sram_ret_o),
  .hs_osc_en_o    (hs_osc_en_o)
);

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_we_i = 1'b0;
  logic [1:0] mode_wdata_i = 2'b00;
  logic [2:0] ret_mask_i = 3'b000;
  logic [3:0] per_mask_i = 4'b0000;
  logic [2:0] keep_mask_i = 3'b000;
  logic       dbg_hold_i = 1'b0;
  logic       wake_i = 1'b0;
  logic       step_ack_i = 1'b0;
  logic       osc_rdy_i = 1'b0;
  logic [1:0] mode_field_o, mode_stat_o;
  logic       cpu_clk_en_o, logic_pwr_en_o, hs_osc_en_o;
  logic [3:0] per_clk_en_o, sram_pwr_en_o, sram_ret_o;
  logic [2:0] bias_en_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pwr_mode_ctrl u0 (.*);

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] d);
    mode_we_i = 1'b1; mode_wdata_i = d;
    tick();
    mode_we_i = 1'b0;
  endtask

  task automatic ack();
    step_ack_i = 1'b1; tick(); step_ack_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    tick(); tick();
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "field", mode_field_o, 2'b00);
    chk("R1", "stat", mode_stat_o, 2'b00);
    chk("R1", "enables", {cpu_clk_en_o, per_clk_en_o, logic_pwr_en_o, sram_pwr_en_o, hs_osc_en_o, bias_en_o}, 14'h3fff);
    chk("R1", "ret", sram_ret_o, 4'h0);
  endtask

  task automatic t_flexi();
    per_mask_i = 4'b0101;
    wr(2'b01);
    @(negedge clk_i);
    chk("R2", "field flexi", mode_field_o, 2'b01);
    tick(); @(negedge clk_i);
    chk("R3", "stat", mode_stat_o, 2'b01);
    chk("R3", "cpu", cpu_clk_en_o, 1'b0);
    chk("R3", "per", per_clk_en_o, 4'b0101);
    per_mask_i = 4'b1010;
    @(negedge clk_i);
    chk("R3", "per follow", per_clk_en_o, 4'b1010);
    dbg_hold_i = 1'b1;
    @(negedge clk_i);
    chk("R9", "dbg cpu", cpu_clk_en_o, 1'b1);
    chk("R9", "dbg stat", mode_stat_o, 2'b00);
    dbg_hold_i = 1'b0;
  endtask

  task automatic t_reserved();
    wr(2'b11);
    @(negedge clk_i);
    chk("R2", "rsv field", mode_field_o, 2'b00);
    tick(); @(negedge clk_i);
    chk("R3", "back active", {mode_stat_o, cpu_clk_en_o, per_clk_en_o}, {2'b00, 1'b1, 4'hf});
  endtask

  task automatic t_hib_entry();
    ret_mask_i = 3'b010; keep_mask_i = 3'b101;
    dbg_hold_i = 1'b1;
    wr(2'b10);
    tick(); tick(); @(negedge clk_i);
    chk("R9", "no entry", {mode_stat_o, cpu_clk_en_o}, {2'b00, 1'b1});
    dbg_hold_i = 1'b0;
    tick(); @(negedge clk_i);
    chk("R10", "busy", mode_stat_o, 2'b11);
    chk("R4", "clk gated", {cpu_clk_en_o, per_clk_en_o}, 5'h00);
    chk("R4", "still powered", {logic_pwr_en_o, sram_pwr_en_o, hs_osc_en_o}, 6'h3f);
    chk("R4", "no ret yet", sram_ret_o, 4'h0);
    tick(); @(negedge clk_i);
    chk("R4", "stall no ack", sram_ret_o, 4'h0);
    ack(); @(negedge clk_i);
    chk("R5", "ret vec", sram_ret_o, 4'b0101);
    chk("R4", "ret step powered", {logic_pwr_en_o, sram_pwr_en_o}, 5'h1f);
    dbg_hold_i = 1'b1;
    ack(); @(negedge clk_i);
    chk("R9", "frozen", {logic_pwr_en_o, sram_pwr_en_o, sram_ret_o}, {1'b1, 4'hf, 4'b0101});
    dbg_hold_i = 1'b0;
    ret_mask_i = 3'b111; keep_mask_i = 3'b000;
    ack(); @(negedge clk_i);
    chk("R6", "logic off", logic_pwr_en_o, 1'b0);
    chk("R5", "sram pwr", sram_pwr_en_o, 4'b0101);
    chk("R6", "bias", bias_en_o, 3'b101);
    chk("R4", "osc still on", hs_osc_en_o, 1'b1);
    ack(); @(negedge clk_i);
    chk("R4", "osc off", hs_osc_en_o, 1'b0);
    chk("R10", "busy osc", mode_stat_o, 2'b11);
    ack(); @(negedge clk_i);
    chk("R7", "hib stat", mode_stat_o, 2'b10);
    chk("R7", "hib clocks", {cpu_clk_en_o, per_clk_en_o, hs_osc_en_o}, 6'h00);
    ack(); @(negedge clk_i);
    chk("R7", "ack ignored", mode_stat_o, 2'b10);
    chk("R5", "late mask ignored", sram_pwr_en_o, 4'b0101);
  endtask

  task automatic t_wake();
    wake_i = 1'b1; tick(); wake_i = 1'b0;
    @(negedge clk_i);
    chk("R8", "osc restart", {hs_osc_en_o, logic_pwr_en_o}, 2'b10);
    chk("R10", "busy wake", mode_stat_o, 2'b11);
    tick(); @(negedge clk_i);
    chk("R8", "wait rdy", {hs_osc_en_o, logic_pwr_en_o, sram_pwr_en_o}, {2'b10, 4'b0101});
    osc_rdy_i = 1'b1; tick(); osc_rdy_i = 1'b0;
    @(negedge clk_i);
    chk("R8", "power back", {logic_pwr_en_o, sram_pwr_en_o}, 5'h1f);
    chk("R8", "ret held", {sram_ret_o, cpu_clk_en_o}, {4'b0101, 1'b0});
    ack(); @(negedge clk_i);
    chk("R8", "ret released", {sram_ret_o, cpu_clk_en_o}, 5'h00);
    ack(); @(negedge clk_i);
    chk("R8", "active", {mode_stat_o, cpu_clk_en_o, mode_field_o}, {2'b00, 1'b1, 2'b00});
    tick(); @(negedge clk_i);
    chk("R8", "stays active", mode_stat_o, 2'b00);
  endtask

  task automatic t_min_ret();
    ret_mask_i = 3'b000; keep_mask_i = 3'b000;
    wr(2'b10);
    tick();
    for (int i = 0; i < 4; i++) ack();
    @(negedge clk_i);
    chk("R7", "hib again", mode_stat_o, 2'b10);
    chk("R5", "fixed only", {sram_pwr_en_o, sram_ret_o}, {4'b0001, 4'b0001});
    chk("R6", "bias off", bias_en_o, 3'b000);
  endtask

  initial begin
    t_reset();
    t_flexi();
    t_reserved();
    t_hib_entry();
    t_wake();
    t_min_ret();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule